// File: doc/BRIEF.md
# Soft Mute and Ramp Event Flagger

This block sits beside the control registers of an audio converter and turns mute and standby changes into timed gain ramps. A change of the playback converter's mute bit starts a gain ramp downwards (mute asserted) or upwards (mute released). Leaving headphone standby while the headphone is unmuted starts an amplifier ramp-up. Muting the headphone starts a ramp-down. Each ramp is a step counter of `RAMP_LEN` cycles. When it ends, it raises a sticky completion flag.

Three further sources (a short-circuit event, a jack event and a short-circuit-cleared event) arrive as single-cycle pulses and are latched into the same flag register. Software acknowledges a flag by writing one to it. A mask register keeps selected flags off the interrupt line, and a two-bit form field picks how that line signals.

Top module: `soft_mute_flagger`

## Requirements
- R1: After reset, flags read 0x00, mask reads 0x7F, the form field is 0 and irq is low. The stored converter and headphone control bits come up with mute=1 and standby=1.
- R2: Writes use address 0 for converter control (bit 7 mute, bit 4 standby), 1 for headphone control (bit 7 mute, bit 4 standby), 2 for the flag register, 3 for the mask and 4 for interrupt control (form in bits 7:6). Writes to addresses 5 to 7 change nothing.
- R3: With converter standby written as 0, a converter mute change 0→1 sets flag bit 0 (gain-down done) exactly `RAMP_LEN` cycles after the write edge. A change 1→0 sets flag bit 1 (gain-up done) the same way.
- R4: A converter write that changes mute while the written standby bit is 1 starts no ramp, and flag bits 1:0 stay unchanged.
- R5: A mute change during a running gain ramp restarts the count in the new direction. Only the final direction's flag is set.
- R6: A headphone write that takes standby from 1 to 0 with the written mute bit 0 sets flag bit 3 (ramp-up done) `RAMP_LEN` cycles after the write edge.
- R7: A headphone write that takes mute from 0 to 1 sets flag bit 2 (ramp-down done) `RAMP_LEN` cycles after the write edge.
- R8: A pulse on ext_short, ext_jack or ext_short_clr sets flag bit 4, 5 or 6 respectively at the next edge. Every flag stays set until cleared.
- R9: Writing to address 2 clears each flag bit whose data bit is 1, and 0x7F clears all flags. A set and a clear of the same bit in one cycle leaves it set.
- R10: Writing to address 3 loads mask from wr_data[6:0]. A flag whose mask bit is 1 does not affect irq.
- R11: With pending meaning any flag set with its mask bit 0, form 0 drives irq equal to pending and form 1 drives irq equal to not pending.
- R12: Form 2 drives irq high for exactly one cycle when pending rises. Form 3 drives irq low for exactly one cycle when pending rises, and high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | 8 | Write data |
| ext_short | input | 1 | Short-circuit event pulse |
| ext_jack | input | 1 | Jack event pulse |
| ext_short_clr | input | 1 | Short-circuit-cleared event pulse |
| flags | output | 7 | Sticky event flags |
| mask | output | 7 | Interrupt mask |
| irq | output | 1 | Interrupt line, shape set by the form field |

## Verification
The bench builds the block with `RAMP_LEN` set to 8. This keeps each ramp short, so a single run can cover many ramps, a restart part-way through a ramp, and the sampling of a flag in both the last cycle before it sets and the cycle it sets. A seeded random phase with the ramps idle mixes event pulses, flag clears and mask writes. It checks that set beats clear and that irq follows the masked flags. Directed cases cover the standby suppression, the writes to unused addresses and all four interrupt forms.

// File: rtl/mute_ramp_pkg.sv
package mute_ramp_pkg;
    localparam int FLAG_W = 7;

    localparam int F_GAIN_DN  = 0;
    localparam int F_GAIN_UP  = 1;
    localparam int F_RAMP_DN  = 2;
    localparam int F_RAMP_UP  = 3;
    localparam int F_SHORT    = 4;
    localparam int F_JACK     = 5;
    localparam int F_SHORT_CL = 6;

    typedef enum logic [2:0] {
        A_DAC  = 3'd0,
        A_HP   = 3'd1,
        A_FLAG = 3'd2,
        A_MASK = 3'd3,
        A_IRQC = 3'd4
    } reg_sel_e;

    typedef enum logic [1:0] {
        FORM_HIGH  = 2'd0,
        FORM_LOW   = 2'd1,
        FORM_PHIGH = 2'd2,
        FORM_PLOW  = 2'd3
    } irq_form_e;

    typedef struct packed {
        logic start;
        logic down;
    } ramp_req_t;

    typedef struct packed {
        logic done;
        logic down;
    } ramp_end_t;

    function automatic logic shape_irq(input irq_form_e f, input logic pend, input logic edge_up);
        case (f)
            FORM_HIGH:  return pend;
            FORM_LOW:   return !pend;
            FORM_PHIGH: return edge_up;
            default:    return !edge_up;
        endcase
    endfunction
endpackage

// File: rtl/ramp_unit.sv
module ramp_unit
    import mute_ramp_pkg::*;
#(
    parameter int LEN = 32
) (
    input  logic      clk,
    input  logic      rst,
    input  ramp_req_t req,
    output ramp_end_t fin
);
    localparam int CNT_W = $clog2(LEN + 1);

    logic [CNT_W-1:0] cnt;
    logic             dir_down;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            dir_down <= 1'b0;
        end else if (req.start) begin
            cnt      <= CNT_W'(LEN);
            dir_down <= req.down;
        end else if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    always_comb begin
        fin.done = (cnt == CNT_W'(1)) && !req.start;
        fin.down = dir_down;
    end
endmodule

// File: rtl/ctrl_decoder.sv
module ctrl_decoder
    import mute_ramp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  logic [2:0] wr_addr,
    input  logic      d_mute,
    input  logic      d_sb,
    input  logic [1:0] d_form,
    output ramp_req_t gain_req,
    output ramp_req_t hp_req,
    output irq_form_e form
);
    logic dac_mute, dac_sb, hp_mute, hp_sb;
    logic wr_dac, wr_hp;

    assign wr_dac = wr_en && (wr_addr == A_DAC);
    assign wr_hp  = wr_en && (wr_addr == A_HP);

    always_ff @(posedge clk) begin
        if (rst) begin
            dac_mute <= 1'b1;
            dac_sb   <= 1'b1;
            hp_mute  <= 1'b1;
            hp_sb    <= 1'b1;
            form     <= FORM_HIGH;
        end else if (wr_en) begin
            if (wr_dac) begin
                dac_mute <= d_mute;
                dac_sb   <= d_sb;
            end
            if (wr_hp) begin
                hp_mute <= d_mute;
                hp_sb   <= d_sb;
            end
            if (wr_addr == A_IRQC) form <= irq_form_e'(d_form);
        end
    end

    always_comb begin
        gain_req.start = wr_dac && (d_mute != dac_mute) && !d_sb;
        gain_req.down  = d_mute;
        hp_req.start   = wr_hp && ((!hp_mute && d_mute) ||
                                   (hp_sb && !d_sb && !d_mute));
        hp_req.down    = d_mute;
    end
endmodule

// File: rtl/flag_bank.sv
module flag_bank
    import mute_ramp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_wr,
    input  logic              mask_wr,
    input  logic [FLAG_W-1:0] wdata,
    input  logic [FLAG_W-1:0] set_vec,
    output logic [FLAG_W-1:0] flags,
    output logic [FLAG_W-1:0] mask
);
    logic [FLAG_W-1:0] clr_vec;
    assign clr_vec = clr_wr ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
            mask  <= '1;
        end else begin
            flags <= (flags & ~clr_vec) | set_vec;
            if (mask_wr) mask <= wdata;
        end
    end
endmodule

// File: rtl/irq_former.sv
module irq_former
    import mute_ramp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  irq_form_e         form,
    input  logic [FLAG_W-1:0] flags,
    input  logic [FLAG_W-1:0] mask,
    output logic              irq
);
    logic pend, pend_d;
    assign pend = |(flags & ~mask);

    always_ff @(posedge clk) begin
        if (rst) pend_d <= 1'b0;
        else     pend_d <= pend;
    end

    assign irq = shape_irq(form, pend, pend && !pend_d);
endmodule

// File: rtl/soft_mute_flagger.sv
module soft_mute_flagger
    import mute_ramp_pkg::*;
#(
    parameter int RAMP_LEN = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       ext_short,
    input  logic       ext_jack,
    input  logic       ext_short_clr,
    output logic [6:0] flags,
    output logic [6:0] mask,
    output logic       irq
);
    ramp_req_t gain_req, hp_req;
    ramp_end_t gain_fin, hp_fin;
    irq_form_e irq_form_w;
    logic [FLAG_W-1:0] set_vec;

    ctrl_decoder u_dec (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .d_mute(wr_data[7]), .d_sb(wr_data[4]), .d_form(wr_data[7:6]),
        .gain_req(gain_req), .hp_req(hp_req), .form(irq_form_w)
    );

    ramp_unit #(.LEN(RAMP_LEN)) u_gain (.clk(clk), .rst(rst), .req(gain_req), .fin(gain_fin));
    ramp_unit #(.LEN(RAMP_LEN)) u_hp   (.clk(clk), .rst(rst), .req(hp_req),   .fin(hp_fin));

    always_comb begin
        set_vec             = '0;
        set_vec[F_GAIN_DN]  = gain_fin.done &&  gain_fin.down;
        set_vec[F_GAIN_UP]  = gain_fin.done && !gain_fin.down;
        set_vec[F_RAMP_DN]  = hp_fin.done   &&  hp_fin.down;
        set_vec[F_RAMP_UP]  = hp_fin.done   && !hp_fin.down;
        set_vec[F_SHORT]    = ext_short;
        set_vec[F_JACK]     = ext_jack;
        set_vec[F_SHORT_CL] = ext_short_clr;
    end

    flag_bank u_flags (
        .clk(clk), .rst(rst),
        .clr_wr(wr_en && wr_addr == A_FLAG),
        .mask_wr(wr_en && wr_addr == A_MASK),
        .wdata(wr_data[6:0]), .set_vec(set_vec),
        .flags(flags), .mask(mask)
    );

    irq_former u_irq (
        .clk(clk), .rst(rst), .form(irq_form_w),
        .flags(flags), .mask(mask), .irq(irq)
    );
endmodule

// File: rtl/soft_mute_flagger_chk.sv
module soft_mute_flagger_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [2:0] wr_addr,
    input logic [7:0] wr_data,
    input logic       ext_short,
    input logic       ext_jack,
    input logic       ext_short_clr,
    input logic [6:0] flags,
    input logic [6:0] mask,
    input logic       irq,
    input logic [1:0] form
);
    assert_jack_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (flags[5] && !(wr_en && wr_addr == 3'd2 && wr_data[5])) |=> flags[5]);

    assert_short_needs_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        (!flags[4] && !ext_short) |=> !flags[4]);

    assert_w1c_clears_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 3'd2 && wr_data[6] && !ext_short_clr) |=> !flags[6]);

    assert_set_beats_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (ext_jack && wr_en && wr_addr == 3'd2 && wr_data[5]) |=> flags[5]);

    assert_mask_load_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 3'd3) |=> (mask == $past(wr_data[6:0])));

    assert_one_gain_dir_R5: assert property (@(posedge clk) disable iff (rst)
        !($rose(flags[0]) && $rose(flags[1])));

    assert_level_form_R11: assert property (@(posedge clk) disable iff (rst)
        (form == 2'd0) |-> (irq == |(flags & ~mask)));

    assert_pulse_short_R12: assert property (@(posedge clk) disable iff (rst)
        (form == 2'd2 && irq) |=> !(irq && form == 2'd2));
endmodule

bind soft_mute_flagger soft_mute_flagger_chk u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ext_short(ext_short), .ext_jack(ext_jack), .ext_short_clr(ext_short_clr),
    .flags(flags), .mask(mask), .irq(irq), .form(irq_form_w)
);

// File: tb/soft_mute_flagger_test.sv
`timescale 1ns/1ps
module soft_mute_flagger_test;
    localparam int L = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       ext_short = 1'b0, ext_jack = 1'b0, ext_short_clr = 1'b0;
    logic [6:0] flags, mask;
    logic       irq;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    soft_mute_flagger #(.RAMP_LEN(L)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ext_short(ext_short), .ext_jack(ext_jack), .ext_short_clr(ext_short_clr),
        .flags(flags), .mask(mask), .irq(irq)
    );

    function automatic logic [6:0] next_flags(input logic [6:0] f, input logic [6:0] clr,
                                              input logic [6:0] set);
        return (f & ~clr) | set;
    endfunction

    function automatic logic level_irq(input logic [6:0] f, input logic [6:0] m, input logic lowform);
        return lowform ? !(|(f & ~m)) : |(f & ~m);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [6:0] ef, em;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset values
        chk("R1 flags", flags, 7'h00);
        chk("R1 mask", mask, 7'h7F);
        chk("R1 irq", irq, 1'b0);

        wr(3'd3, 8'h00);                 // unmask all
        // R4: mute change with standby written 1 -> no ramp
        wr(3'd0, 8'h10);
        idle(L + 2);
        chk("R4 no gain flag", flags[1:0], 2'b00);
        // R2: stray addresses change nothing
        wr(3'd5, 8'hFF); wr(3'd6, 8'h7F); wr(3'd7, 8'h80);
        chk("R2 stray flags", flags, 7'h00);
        chk("R2 stray mask", mask, 7'h00);
        // R3 gain-up: mute 0 with standby 0 (current mute 0, so set mute first)
        wr(3'd0, 8'h80);                 // mute 0->1, standby 0: gain-down
        idle(L - 1);
        chk("R3 gain-down not early", flags[0], 1'b0);
        idle(1);
        chk("R3 gain-down set", flags[0], 1'b1);
        chk("R11 level irq", irq, 1'b1);
        wr(3'd2, 8'h7F);
        chk("R9 clear all", flags, 7'h00);
        wr(3'd0, 8'h00);                 // gain-up
        idle(L - 1);
        chk("R3 gain-up not early", flags[1], 1'b0);
        idle(1);
        chk("R3 gain-up set", flags[1:0], 2'b10);
        wr(3'd2, 8'h02);
        // R5 restart mid-ramp
        wr(3'd0, 8'h80);
        idle(2);
        wr(3'd0, 8'h00);
        idle(L + 2);
        chk("R5 only final dir", flags[1:0], 2'b10);
        wr(3'd2, 8'h7F);
        // R6 headphone ramp-up: hp reset mute=1 standby=1
        wr(3'd1, 8'h80);                 // leave standby but muted: nothing
        idle(L + 2);
        chk("R6 muted no ramp-up", flags[3:2], 2'b00);
        wr(3'd1, 8'h10);                 // unmute while in standby: nothing
        idle(L + 2);
        chk("R6 standby no ramp", flags[3:2], 2'b00);
        wr(3'd1, 8'h00);
        idle(L - 1);
        chk("R6 ramp-up not early", flags[3], 1'b0);
        idle(1);
        chk("R6 ramp-up set", flags[3:2], 2'b10);
        wr(3'd2, 8'h08);
        // R7 ramp-down
        wr(3'd1, 8'h80);
        idle(L);
        chk("R7 ramp-down set", flags[3:2], 2'b01);
        wr(3'd2, 8'h7F);
        // R9 set wins over clear in the same cycle
        @(negedge clk);
        ext_jack = 1'b1; wr_en = 1'b1; wr_addr = 3'd2; wr_data = 8'h20;
        @(negedge clk);
        ext_jack = 1'b0; wr_en = 1'b0;
        chk("R9 set wins", flags[5], 1'b1);
        // R10 mask hides flag
        wr(3'd3, 8'h20);
        chk("R10 masked irq", irq, 1'b0);
        // R11 active-low form
        wr(3'd4, 8'h40);
        chk("R11 low form idle", irq, 1'b1);
        wr(3'd3, 8'h00);
        chk("R11 low form active", irq, 1'b0);
        wr(3'd2, 8'h7F);
        // R12 pulse-high
        wr(3'd4, 8'h80);
        @(negedge clk); ext_short = 1'b1;
        @(negedge clk); ext_short = 1'b0;
        chk("R12 high pulse", irq, 1'b1);
        @(negedge clk);
        chk("R12 high pulse ends", irq, 1'b0);
        chk("R8 short sticky", flags[4], 1'b1);
        wr(3'd2, 8'h7F);
        // R12 pulse-low
        wr(3'd4, 8'hC0);
        chk("R12 low idle", irq, 1'b1);
        @(negedge clk); ext_short_clr = 1'b1;
        @(negedge clk); ext_short_clr = 1'b0;
        chk("R12 low pulse", irq, 1'b0);
        @(negedge clk);
        chk("R12 low pulse ends", irq, 1'b1);
        chk("R8 short-clr sticky", flags[6], 1'b1);

        // random phase, ramps idle, form 0
        wr(3'd4, 8'h00);
        ef = flags; em = mask;
        for (int i = 0; i < 300; i++) begin
            logic [6:0] setv, clrv;
            logic [2:0] r;
            r = 3'($urandom);
            ext_short     = ($urandom % 5) == 0;
            ext_jack      = ($urandom % 5) == 0;
            ext_short_clr = ($urandom % 5) == 0;
            wr_en   = r[0];
            wr_addr = r[1] ? 3'd3 : 3'd2;
            wr_data = 8'($urandom);
            setv = {ext_short_clr, ext_jack, ext_short, 4'b0};
            clrv = (wr_en && wr_addr == 3'd2) ? wr_data[6:0] : 7'h00;
            ef = next_flags(ef, clrv, setv);
            if (wr_en && wr_addr == 3'd3) em = wr_data[6:0];
            @(negedge clk);
            chk("R8 R9 random flags", flags, ef);
            chk("R10 random mask", mask, em);
            chk("R11 random irq", irq, level_irq(ef, em, 1'b0));
        end
        ext_short = 0; ext_jack = 0; ext_short_clr = 0; wr_en = 0;
        idle(2);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule